// File: doc/BRIEF.md
# Dual-Bank Multiport Register File

This block is a data register file of 40-bit words, organised as two banks of sixteen registers each: a primary bank and a shadow (secondary) bank. One mode bit picks which bank the register indices refer to. An interrupt handler sets the bit on entry and clears it on exit. The interrupted program's registers then stay untouched in the other bank, and no save or restore sequence is needed.

Ten ports reach the file in the same cycle: six combinational read ports and four write ports. Every port carries a 4-bit register index, and that index is decoded against the bank that is currently active. Writes land on the rising clock edge. When several write ports name the same register, the port with the highest number wins.

Top module: `dual_bank_regfile`

## Requirements
- R1: While reset is asserted (rst_ni low), and on leaving it, all 32 registers in both banks hold zero and the primary bank is active. Every read port therefore returns zero until something is written.
- R2: When a write port has its enable bit set, the rising edge stores that port's data in the register it indexes within the bank active in that cycle.
- R3: A read port returns the register's stored contents combinationally. In the cycle of a write, a read of the same register still returns the old value. The new value appears only after the edge.
- R4: When two or more enabled write ports index the same register in one cycle, the highest-numbered of those ports decides the stored value (port 3 over 2 over 1 over 0).
- R5: A write port whose enable bit is 0 changes no register, whatever its index and data.
- R6: bank_sel_i = 0 selects the primary bank and 1 selects the secondary bank. A change of bank_sel_i takes effect at the next rising edge. Writes and reads in the cycle of the change still use the bank that was active before it.
- R7: The inactive bank keeps its contents unchanged. The same index in the two banks names two different registers.
- R8: The six read ports are independent. Each returns the register named by its own index, in any combination, including several ports reading one register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous reset, active low |
| bank_sel_i | input | 1 | Bank mode bit: 0 primary, 1 secondary |
| raddr_i | input | 6x4 | Register index of each read port |
| rdata_o | output | 6x40 | Read data of each read port |
| we_i | input | 4 | Write enable of each write port |
| waddr_i | input | 4x4 | Register index of each write port |
| wdata_i | input | 4x40 | Write data of each write port |

## Verification
Two events can fall in the same cycle. The first is a write landing together with a change of the bank bit. The second is several write ports colliding on one index while reads target that same index. The bench provokes both with directed cycles, and then with random traffic drawn over only a few indices so that collisions occur often. A bench model applies the port-priority rule and the bank-switch timing. Each read port is compared with that model just before every clock edge, which judges both the stored value and the absence of any bypass.

// File: rtl/dbrf_pkg.sv
package dbrf_pkg;

    typedef enum logic {
        BANK_MAIN   = 1'b0,
        BANK_SHADOW = 1'b1
    } bank_e;

endpackage

// File: rtl/dbrf_wr_arb.sv
module dbrf_wr_arb #(
    parameter int unsigned NREG  = 16,
    parameter int unsigned NWR   = 4,
    parameter int unsigned DW    = 40,
    localparam int unsigned IDXW = $clog2(NREG)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NWR-1:0]            we_i,
    input  logic [NWR-1:0][IDXW-1:0]  waddr_i,
    input  logic [NWR-1:0][DW-1:0]    wdata_i,
    output logic [NREG-1:0]           reg_we_o,
    output logic [NREG-1:0][DW-1:0]   reg_wd_o
);

    always_comb begin
        reg_we_o = '0;
        reg_wd_o = '0;
        for (int k = 0; k < NREG; k++) begin
            // ascending scan: a later (higher) port overrides an earlier one
            for (int p = 0; p < NWR; p++) begin
                if (we_i[p] && (waddr_i[p] == IDXW'(k))) begin
                    reg_we_o[k] = 1'b1;
                    reg_wd_o[k] = wdata_i[p];
                end
            end
        end
    end

    // R4
    top_port_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i[NWR-1] |-> (reg_we_o[waddr_i[NWR-1]] && reg_wd_o[waddr_i[NWR-1]] == wdata_i[NWR-1]));

endmodule

// File: rtl/dbrf_bank.sv
module dbrf_bank #(
    parameter int unsigned NREG = 16,
    parameter int unsigned DW   = 40
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      active_i,
    input  logic [NREG-1:0]           reg_we_i,
    input  logic [NREG-1:0][DW-1:0]   reg_wd_i,
    output logic [NREG-1:0][DW-1:0]   regs_o
);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (active_i) begin
            for (int k = 0; k < NREG; k++) begin
                if (reg_we_i[k]) st_d.regs[k] = reg_wd_i[k];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign regs_o = st_q.regs;

    // R7
    idle_bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active_i |=> $stable(regs_o));

endmodule

// File: rtl/dbrf_rd_mux.sv
module dbrf_rd_mux #(
    parameter int unsigned NREG  = 16,
    parameter int unsigned NRD   = 6,
    parameter int unsigned DW    = 40,
    localparam int unsigned IDXW = $clog2(NREG)
) (
    input  dbrf_pkg::bank_e           bank_i,
    input  logic [NREG-1:0][DW-1:0]   main_regs_i,
    input  logic [NREG-1:0][DW-1:0]   shad_regs_i,
    input  logic [NRD-1:0][IDXW-1:0]  raddr_i,
    output logic [NRD-1:0][DW-1:0]    rdata_o
);

    for (genvar r = 0; r < NRD; r++) begin : g_rport
        assign rdata_o[r] = (bank_i == dbrf_pkg::BANK_SHADOW) ?
                            shad_regs_i[raddr_i[r]] : main_regs_i[raddr_i[r]];
    end

endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile #(
    parameter int unsigned NREG  = 16,
    parameter int unsigned NRD   = 6,
    parameter int unsigned NWR   = 4,
    parameter int unsigned DW    = 40,
    localparam int unsigned IDXW = $clog2(NREG),
    localparam int unsigned NBANK = 2
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      bank_sel_i,
    input  logic [NRD-1:0][IDXW-1:0]  raddr_i,
    output logic [NRD-1:0][DW-1:0]    rdata_o,
    input  logic [NWR-1:0]            we_i,
    input  logic [NWR-1:0][IDXW-1:0]  waddr_i,
    input  logic [NWR-1:0][DW-1:0]    wdata_i
);
    import dbrf_pkg::*;

    typedef struct packed {
        bank_e bank;
    } mode_st_t;

    mode_st_t mode_d, mode_q;

    logic [NREG-1:0]                       reg_we;
    logic [NREG-1:0][DW-1:0]               reg_wd;
    logic [NBANK-1:0][NREG-1:0][DW-1:0]    bank_regs;

    always_comb begin
        mode_d      = mode_q;
        mode_d.bank = bank_e'(bank_sel_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) mode_q <= '{bank: BANK_MAIN};
        else         mode_q <= mode_d;
    end

    dbrf_wr_arb #(.NREG(NREG), .NWR(NWR), .DW(DW)) u_arb (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (we_i),
        .waddr_i  (waddr_i),
        .wdata_i  (wdata_i),
        .reg_we_o (reg_we),
        .reg_wd_o (reg_wd)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        dbrf_bank #(.NREG(NREG), .DW(DW)) u_bank (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .active_i (mode_q.bank == bank_e'(b)),
            .reg_we_i (reg_we),
            .reg_wd_i (reg_wd),
            .regs_o   (bank_regs[b])
        );
    end

    dbrf_rd_mux #(.NREG(NREG), .NRD(NRD), .DW(DW)) u_rmux (
        .bank_i      (mode_q.bank),
        .main_regs_i (bank_regs[0]),
        .shad_regs_i (bank_regs[1]),
        .raddr_i     (raddr_i),
        .rdata_o     (rdata_o)
    );

    // R5
    no_enable_no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i == '0) |=> $stable(bank_regs));

    // R2 R3
    write_then_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i[NWR-1] && $stable(bank_sel_i)) |=>
        ((raddr_i[0] != $past(waddr_i[NWR-1])) || (rdata_o[0] == $past(wdata_i[NWR-1]))));

endmodule

// File: tb/dual_bank_regfile_tb_top.sv
`timescale 1ns/1ps
module dual_bank_regfile_tb_top;

    localparam int NREG = 16;
    localparam int NRD  = 6;
    localparam int NWR  = 4;
    localparam int DW   = 40;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   bank_sel;
    logic [NRD-1:0][3:0]    raddr;
    logic [NRD-1:0][DW-1:0] rdata;
    logic [NWR-1:0]         we;
    logic [NWR-1:0][3:0]    waddr;
    logic [NWR-1:0][DW-1:0] wdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [DW-1:0] model [2][NREG];
    int            mbank;

    always #2 clk = ~clk;

    dual_bank_regfile dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .bank_sel_i (bank_sel),
        .raddr_i    (raddr),
        .rdata_o    (rdata),
        .we_i       (we),
        .waddr_i    (waddr),
        .wdata_i    (wdata)
    );

    function automatic logic [DW-1:0] rnd40();
        return {$urandom(), $urandom()} & {DW{1'b1}};
    endfunction

    function automatic logic [DW-1:0] expect_rd(int idx);
        return model[mbank][idx];
    endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: compare reads before the edge, then advance the model
    task automatic cycle(string req);
        #1;
        for (int r = 0; r < NRD; r++) chk(req, rdata[r], expect_rd(int'(raddr[r])));
        @(posedge clk);
        if (rst_n) begin
            for (int p = 0; p < NWR; p++)
                if (we[p]) model[mbank][waddr[p]] = wdata[p];
            mbank = int'(bank_sel);
        end
        @(negedge clk);
    endtask

    task automatic idle();
        we = '0;
        for (int p = 0; p < NWR; p++) begin
            waddr[p] = 4'(p);
            wdata[p] = '0;
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        for (int b = 0; b < 2; b++)
            for (int k = 0; k < NREG; k++) model[b][k] = '0;
        mbank    = 0;
        rst_n    = 1'b0;
        bank_sel = 1'b0;
        raddr    = '0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: zero in both banks after reset
        for (int g = 0; g < 3; g++) begin
            for (int r = 0; r < NRD; r++) raddr[r] = 4'((g * NRD + r) % NREG);
            cycle("R1");
        end
        bank_sel = 1'b1;
        cycle("R1");
        for (int g = 0; g < 3; g++) begin
            for (int r = 0; r < NRD; r++) raddr[r] = 4'((g * NRD + r) % NREG);
            cycle("R1");
        end
        bank_sel = 1'b0;
        cycle("R1");

        // R2 R3: write, read same index in write cycle (old) and after (new)
        we[0] = 1'b1; waddr[0] = 4'd5; wdata[0] = 40'hA5_1234_5678;
        for (int r = 0; r < NRD; r++) raddr[r] = 4'd5;
        cycle("R3");
        idle();
        cycle("R2");

        // R4: all four ports on index 9, port 3 must win
        for (int p = 0; p < NWR; p++) begin
            we[p] = 1'b1; waddr[p] = 4'd9; wdata[p] = 40'h11_0000_0000 * (p + 1);
        end
        raddr[0] = 4'd9;
        cycle("R4");
        idle();
        cycle("R4");
        // R4: ports 0 and 2 collide, port 2 wins
        we[0] = 1'b1; waddr[0] = 4'd3; wdata[0] = 40'h00_DEAD_0000;
        we[2] = 1'b1; waddr[2] = 4'd3; wdata[2] = 40'h00_BEEF_0000;
        raddr[1] = 4'd3;
        cycle("R4");
        idle();
        cycle("R4");

        // R5: disabled ports carry data but store nothing
        for (int p = 0; p < NWR; p++) begin
            waddr[p] = 4'd5; wdata[p] = 40'hFF_FFFF_FFFF;
        end
        raddr[2] = 4'd5;
        cycle("R5");
        idle();
        cycle("R5");

        // R6: write in the cycle bank_sel rises goes to the main bank
        bank_sel = 1'b1;
        we[1] = 1'b1; waddr[1] = 4'd7; wdata[1] = 40'h77_7777_7777;
        raddr[3] = 4'd7;
        cycle("R6");
        idle();
        cycle("R6");
        // R7: shadow write leaves main untouched
        we[3] = 1'b1; waddr[3] = 4'd7; wdata[3] = 40'h0C_0C0C_0C0C;
        cycle("R7");
        idle();
        bank_sel = 1'b0;
        cycle("R7");
        cycle("R7");
        bank_sel = 1'b1;
        cycle("R6");
        cycle("R7");

        // R8 with random traffic over a narrow index range
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 7) == 0) bank_sel = ~bank_sel;
            for (int p = 0; p < NWR; p++) begin
                we[p]    = 1'($urandom_range(0, 1));
                waddr[p] = 4'($urandom_range(0, (n % 2) ? 15 : 3));
                wdata[p] = rnd40();
            end
            for (int r = 0; r < NRD; r++) raddr[r] = 4'($urandom_range(0, 15));
            cycle("R8");
        end
        idle();
        for (int g = 0; g < 2; g++) begin
            bank_sel = 1'(g);
            cycle("R7");
            for (int s = 0; s < 3; s++) begin
                for (int r = 0; r < NRD; r++) raddr[r] = 4'((s * NRD + r) % NREG);
                cycle("R7");
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual hung expected done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule